// File: doc/BRIEF.md
# Integer Multiply Unit with Carry and Overflow Flags

This block multiplies two 32-bit operands over several cycles and reports a carry flag and an overflow flag beside the result. A two-bit mode input picks one of three operations. The first is an unsigned multiply that keeps the full 64-bit product. The second is a signed multiply that also keeps the full 64-bit product. The third is a signed multiply that keeps only the low 32 bits. The flags show whether the product needed more bits than the narrower form of the result can hold.

A one-cycle `start` strobe captures the operands and the mode while the unit is idle. The unit converts signed operands to magnitudes and builds the product with one shift-add step per multiplier bit. It then restores the sign, writes the result words and flags, and raises `done` for one cycle. The result stays on the outputs until the next operation completes. A `start` that arrives while an operation is running is dropped.

Top module: `imul_flags`

## Requirements
- R1: Mode 2'b00 treats both operands as unsigned 32-bit values; `res_lo` gets bits 31:0 and `res_hi` gets bits 63:32 of the 64-bit product.
- R2: In mode 2'b00, `carry` is 1 exactly when `res_hi` is nonzero, and 0 otherwise.
- R3: Mode 2'b01 treats both operands as two's-complement values; `res_hi`:`res_lo` is the 64-bit signed product, split in the same way as R1.
- R4: In mode 2'b01, `carry` is 0 when `res_hi` is all zeros and bit 31 of `res_lo` is 0, or when `res_hi` is all ones and bit 31 of `res_lo` is 1. In every other case `carry` is 1.
- R5: Mode 2'b10 puts the low 32 bits of the signed product on `res_lo` and drives `res_hi` to zero.
- R6: In mode 2'b10, `carry` is 0 when the full 64-bit signed product equals `res_lo` sign-extended to 64 bits, and 1 otherwise.
- R7: `ovf` equals `carry` at all times.
- R8: Mode 2'b11 behaves exactly like mode 2'b10.
- R9: If `start` is sampled high at a rising edge while the unit is idle, `done` goes high for exactly one cycle, 33 rising edges later. The result and the flags become valid in that same cycle.
- R10: `res_hi`, `res_lo`, `carry` and `ovf` change only in a cycle where `done` is high.
- R11: A `start` sampled while an operation is running, including the edge that completes it, is ignored. Neither the operands nor the timing of the running operation change.
- R12: Synchronous active-high `rst` returns the unit to idle and clears `done`, `res_hi`, `res_lo`, `carry` and `ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; acted on only when idle |
| mode | input | 2 | 00 unsigned wide, 01 signed wide, 10/11 signed truncating |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| res_hi | output | 32 | Upper product word (zero in truncating mode) |
| res_lo | output | 32 | Lower product word |
| carry | output | 1 | Product overflowed the narrow result form |
| ovf | output | 1 | Copy of carry |
| done | output | 1 | One-cycle result-valid strobe |

## Verification
Zero and small operands have an empty upper half, so they show whether a flag is raised without cause. All-ones operands produce a maximum-width unsigned product, so they separate an unsigned path from a signed one. The most negative value multiplied by itself, and by minus one, probes the magnitude and negation step: these are the only inputs whose magnitude needs bit 31. They also show whether the signed flag is built from the sign of the low word or only from the upper word. Products of mixed sign that just fit, or just fail to fit, in 32 bits test the truncating flag at its boundary. The bench also issues random operands in every mode, sends a start strobe in the middle of an operation, and issues back-to-back starts. It checks that an ignored strobe changes neither the result nor the timing, and that code 11 matches code 10.

// File: rtl/imul_flags.sv
module imul_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         carry,
  output logic         ovf,
  output logic         done
);
  localparam int CW = $clog2(W);
  localparam int PW = 2 * W;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [PW-1:0]   mcand, acc;
  logic [W-1:0]    mplier;
  logic [1:0]      mode_q;
  logic            neg;
  logic            busy;

  wire             sgn   = (mode != 2'b00);
  wire  [W-1:0]    mag_a = (sgn && op_a[W-1]) ? (~op_a + 1'b1) : op_a;
  wire  [W-1:0]    mag_b = (sgn && op_b[W-1]) ? (~op_b + 1'b1) : op_b;
  wire  [PW-1:0]   prod  = neg ? (~acc + 1'b1) : acc;
  wire  [W-1:0]    p_hi  = prod[PW-1:W];
  wire  [W-1:0]    p_lo  = prod[W-1:0];
  wire             fits  = (p_hi == {W{p_lo[W-1]}});
  wire             flag  = (mode_q == 2'b00) ? (p_hi != '0) : !fits;

  assign busy = (state != S_IDLE);
  assign ovf  = carry;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      mcand  <= '0;
      acc    <= '0;
      mplier <= '0;
      mode_q <= 2'b00;
      neg    <= 1'b0;
      res_hi <= '0;
      res_lo <= '0;
      carry  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state  <= S_RUN;
          cnt    <= '0;
          mcand  <= {{W{1'b0}}, mag_a};
          mplier <= mag_b;
          acc    <= '0;
          mode_q <= mode;
          neg    <= sgn && (op_a[W-1] ^ op_b[W-1]);
        end
        S_RUN: begin
          if (mplier[0]) acc <= acc + mcand;
          mcand  <= mcand << 1;
          mplier <= mplier >> 1;
          cnt    <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) state <= S_FIN;
        end
        default: begin
          state  <= S_IDLE;
          res_lo <= p_lo;
          res_hi <= mode_q[1] ? '0 : p_hi;
          carry  <= flag;
          done   <= 1'b1;
        end
      endcase
    end
  end
endmodule

module imul_flags_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [1:0]   mode,
  input logic         busy,
  input logic [W-1:0] res_hi,
  input logic [W-1:0] res_lo,
  input logic         carry,
  input logic         ovf,
  input logic         done
);
  logic       armed;
  logic [1:0] lmode;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      lmode <= 2'b00;
    end else begin
      armed <= 1'b1;
      if (start && !busy) lmode <= mode;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7
  flag_pair_chk: assert property (@(posedge clk) disable iff (rst) carry == ovf);
  // R2
  uns_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (done && lmode == 2'b00) |-> (carry == (res_hi != '0)));
  // R4
  sgn_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (done && lmode == 2'b01) |-> (carry == !((res_hi == '0 && !res_lo[W-1]) ||
                                             (res_hi == '1 &&  res_lo[W-1]))));
  // R5
  trunc_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (done && lmode[1]) |-> (res_hi == '0));
  // R10
  hold_lo_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !done |-> ($stable(res_lo) && $stable(res_hi) && $stable(carry)));
endmodule

bind imul_flags imul_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .busy(busy),
  .res_hi(res_hi), .res_lo(res_lo), .carry(carry), .ovf(ovf), .done(done)
);

// File: tb/imul_flags_tb.sv
module imul_flags_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [31:0] op_a = '0, op_b = '0;
  logic [31:0] res_hi, res_lo;
  logic        carry, ovf, done;

  imul_flags u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .op_a(op_a), .op_b(op_b),
    .res_hi(res_hi), .res_lo(res_lo), .carry(carry), .ovf(ovf), .done(done)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference state: values expected after the next edge
  bit          m_busy = 0;
  int          m_rem = 0;
  logic [31:0] e_hi = '0, e_lo = '0, p_hi, p_lo;
  logic        e_c = 0, e_done = 0, p_c;
  logic [1:0]  p_mode, e_mode = 2'b00;

  function automatic string tag_res(input logic [1:0] m);
    case (m) 2'b00: return "R1"; 2'b01: return "R3"; 2'b10: return "R5"; default: return "R8"; endcase
  endfunction
  function automatic string tag_flag(input logic [1:0] m);
    case (m) 2'b00: return "R2"; 2'b01: return "R4"; 2'b10: return "R6"; default: return "R8"; endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compute(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] up;
    logic signed [63:0] sp;
    up = {32'b0, a} * {32'b0, b};
    sp = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    p_mode = m;
    if (m == 2'b00) begin
      p_lo = up[31:0]; p_hi = up[63:32]; p_c = (p_hi != 0);
    end else if (m == 2'b01) begin
      p_lo = sp[31:0]; p_hi = sp[63:32];
      p_c = !((p_hi == 32'h0 && !p_lo[31]) || (p_hi == 32'hffffffff && p_lo[31]));
    end else begin
      p_lo = sp[31:0]; p_hi = '0;
      p_c = (sp != $signed({{32{sp[31]}}, sp[31:0]}));
    end
  endtask

  task automatic cycle(input logic r, input logic s, input logic [1:0] m,
                       input logic [31:0] a, input logic [31:0] b);
    string rt;
    rst = r; start = s; mode = m; op_a = a; op_b = b;
    if (r) begin
      m_busy = 0; m_rem = 0; e_hi = '0; e_lo = '0; e_c = 0; e_done = 0; e_mode = 2'b00;
    end else begin
      e_done = 0;
      if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin
          m_busy = 0; e_done = 1; e_hi = p_hi; e_lo = p_lo; e_c = p_c; e_mode = p_mode;
        end
      end else if (s) begin
        m_busy = 1; m_rem = 33; compute(m, a, b);
      end
    end
    @(negedge clk);
    rt = r ? "R12" : "R10";
    chk(r ? "R12" : "R9", "done", {31'b0, done}, {31'b0, e_done});
    chk(r ? "R12" : (e_done ? tag_res(e_mode) : rt), "res_lo", res_lo, e_lo);
    chk(r ? "R12" : (e_done ? tag_res(e_mode) : rt), "res_hi", res_hi, e_hi);
    chk(r ? "R12" : (e_done ? tag_flag(e_mode) : rt), "carry", {31'b0, carry}, {31'b0, e_c});
    chk("R7", "ovf", {31'b0, ovf}, {31'b0, e_c});
  endtask

  task automatic run_op(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b);
    cycle(0, 1, m, a, b);
    for (int i = 0; i < 33; i++) cycle(0, 0, $urandom, $urandom, $urandom);
    cycle(0, 0, 2'b00, '0, '0);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) cycle(1, 0, 2'b00, '0, '0);   // R12 reset state
    run_op(2'b00, 32'h0, 32'hdeadbeef);                       // R1 R2 zero
    run_op(2'b00, 32'h0001_0000, 32'h0000_ffff);              // R2 fits
    run_op(2'b00, 32'hffffffff, 32'hffffffff);                // R1 max
    run_op(2'b01, 32'hffffffff, 32'hffffffff);                // R3 -1*-1
    run_op(2'b01, 32'h80000000, 32'h80000000);                // R3 R4 min*min
    run_op(2'b01, 32'h80000000, 32'h00000001);                // R4 hi ones, bit31 set
    run_op(2'b01, 32'h80000000, 32'hffffffff);                // R4 2^31
    run_op(2'b01, 32'hfffffffe, 32'h00000003);                // R4 small negative
    run_op(2'b10, 32'h0000ffff, 32'h00008001);                // R6 just overflows
    run_op(2'b10, 32'hffff0000, 32'h00008000);                // R6 exact min
    run_op(2'b10, 32'h80000000, 32'hffffffff);                // R6 min*-1
    run_op(2'b11, 32'h12345678, 32'h9abcdef0);                // R8
    run_op(2'b11, 32'hfffffff9, 32'h00000006);                // R8 fits
    // R11: start mid-operation and on the completing edge are ignored
    cycle(0, 1, 2'b00, 32'h7, 32'h9);
    for (int i = 0; i < 10; i++) cycle(0, 0, 2'b01, '0, '0);
    cycle(0, 1, 2'b01, 32'hffffffff, 32'h5);
    for (int i = 0; i < 21; i++) cycle(0, 0, 2'b01, '0, '0);
    cycle(0, 1, 2'b10, 32'h11111111, 32'h3);                  // completing edge
    cycle(0, 1, 2'b01, 32'hfffffffd, 32'h7);                  // back-to-back, accepted
    for (int i = 0; i < 34; i++) cycle(0, 0, 2'b00, '0, '0);
    for (int k = 0; k < 40; k++) run_op(2'(k), $urandom, $urandom);
    // R12 reset mid-operation
    cycle(0, 1, 2'b00, 32'hffffffff, 32'h2);
    for (int i = 0; i < 5; i++) cycle(0, 0, 2'b00, '0, '0);
    cycle(1, 0, 2'b00, '0, '0);
    for (int i = 0; i < 40; i++) cycle(0, 0, 2'b00, '0, '0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule